// File: doc/BRIEF.md
# Four-Lane Simultaneous Serial DAC Updater

This block feeds four single-channel 16-bit serial DACs in parallel. A host gives it one 64-bit word that holds four samples through a valid/ready handshake. The block then shifts each sample out on its own data lane. All four lanes share one serial clock and one active-low chip select, so the four transfers run in lockstep and finish on the same edge.

After chip select returns high, the block raises a one-cycle load strobe. This strobe commits the new codes in every DAC at the same instant, so the four outputs never step at different times. A separate synchronous clear request has priority over everything else. It aborts any transfer in progress, returns the block to idle and emits a one-cycle clear pulse that forces the DACs to their reset code.

The serial clock comes from the system clock. Its half period is set by a runtime count, so the division ratio is always even and is never less than two. With a 100 MHz system clock and the smallest ratio, the serial clock runs at 50 MHz, and a frame of 16 bits plus its framing overhead gives roughly 3 MS/s on every channel at once.

Top module: `lane_dac_updater`

## Requirements
- R1: `s_ready` is high in idle whenever `clr_req` is low. A word is accepted in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low from the next cycle until the load pulse has ended, and high again in the cycle after the load pulse.
- R2: Lane i (`sdo[i]`) carries bits [16*i+15 : 16*i] of the accepted `s_data`, most significant bit first.
- R3: A data lane never changes while `sclk` is high. New bits are presented on the falling edge of `sclk`, and the DACs sample them on the rising edge.
- R4: Each complete frame contains exactly 16 rising edges of `sclk` while `cs_n` is low, and `sclk` is low whenever `cs_n` is high.
- R5: `cs_n` falls in the cycle after acceptance, with `sclk` still low. The first rising edge of `sclk` comes at least one system clock later. `cs_n` rises only after the sixteenth falling edge of `sclk`.
- R6: `dac_load` is high for exactly one system clock per completed frame, starting exactly one clock after `cs_n` rises, with `cs_n` high throughout.
- R7: Each high and each low phase of `sclk` lasts max(`div_half`,1) system clocks. The `sclk` period is therefore 2*max(`div_half`,1) clocks, and a `div_half` of 0 behaves as 1.
- R8: A high `clr_req` holds `s_ready` low. In the following cycle, `cs_n` is high, `sclk` is low, all lanes are 0 and `dac_clear` is high. The aborted frame never produces `dac_load`.
- R9: Changes to `s_data` after acceptance have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Host offers a sample set |
| s_ready | output | 1 | Block can accept a sample set |
| s_data | input | 64 | Four 16-bit samples, lane 0 in the low bits |
| div_half | input | 8 | System clocks per serial clock phase (0 acts as 1) |
| clr_req | input | 1 | Synchronous clear request, highest priority |
| sclk | output | 1 | Shared serial clock |
| cs_n | output | 1 | Shared active-low chip select |
| sdo | output | 4 | One serial data lane per DAC |
| dac_load | output | 1 | One-cycle simultaneous load strobe |
| dac_clear | output | 1 | One-cycle DAC clear pulse |

## Verification
The sample sets are chosen so that a fault shows up clearly:

- All-ones on some lanes next to all-zeros on others exposes stuck or swapped lanes.
- Walking-one and alternating patterns with a different value on each lane expose bit-order reversal, an off-by-one shift count and crossed lane slices.
- Each frame runs at a different half-period setting (0, 1, 3), which separates a correct divider from one that ignores the setting or mishandles zero.

A clear issued partway through a frame, followed by a clean frame, shows that the abort really returns the block to idle and suppresses the load. The input word is overwritten right after acceptance, which shows that the block samples its data only once.

// File: rtl/lane_dac_pkg.sv
package lane_dac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP,
    ST_LOAD
  } frame_st_t;
endpackage

// File: rtl/dac_sclk_tick.sv
module dac_sclk_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_m1;

  // a zero setting behaves like one clock per phase
  assign half_m1 = (half == '0) ? '0 : half - 1'b1;
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_lane_shift.sv
module dac_lane_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              sdo
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clear) sr <= '0;
    else if (load)    sr <= word;
    else if (shift)   sr <= {sr[WORD_W-2:0], 1'b0};
  end

  assign sdo = sr[WORD_W-1];
endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import lane_dac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_req,
  input  logic start,
  input  logic tick,
  output logic ready,
  output logic accept,
  output logic run,
  output logic shift,
  output logic sclk,
  output logic cs_n,
  output logic dac_load,
  output logic dac_clear
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  frame_st_t        st;
  logic [CNT_W-1:0] falls;

  assign ready  = (st == ST_IDLE) && !clr_req;
  assign accept = ready && start;
  assign run    = (st == ST_LEAD) || (st == ST_SHIFT) || (st == ST_TAIL);
  assign shift  = (st == ST_SHIFT) && tick && sclk && (falls != LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      falls     <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      dac_load  <= 1'b0;
      dac_clear <= 1'b0;
    end else begin
      dac_clear <= clr_req;
      dac_load  <= 1'b0;
      if (clr_req) begin
        st   <= ST_IDLE;
        sclk <= 1'b0;
        cs_n <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: if (accept) begin
            st    <= ST_LEAD;
            cs_n  <= 1'b0;
            falls <= '0;
          end
          ST_LEAD: if (tick) begin
            st   <= ST_SHIFT;
            sclk <= 1'b1;
          end
          ST_SHIFT: if (tick) begin
            sclk <= ~sclk;
            if (sclk) begin
              if (falls == LAST) st <= ST_TAIL;
              else               falls <= falls + 1'b1;
            end
          end
          ST_TAIL: if (tick) begin
            st   <= ST_GAP;
            cs_n <= 1'b1;
          end
          ST_GAP: begin
            st       <= ST_LOAD;
            dac_load <= 1'b1;
          end
          ST_LOAD: st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lane_dac_updater.sv
module lane_dac_updater #(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 16,
  parameter int DIV_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [NUM_LANES*WORD_W-1:0] s_data,
  input  logic [DIV_W-1:0]            div_half,
  input  logic                        clr_req,
  output logic                        sclk,
  output logic                        cs_n,
  output logic [NUM_LANES-1:0]        sdo,
  output logic                        dac_load,
  output logic                        dac_clear
);
  logic tick, run, accept, shift;

  dac_sclk_tick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .run(run), .half(div_half), .tick(tick)
  );

  dac_frame_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rst(rst), .clr_req(clr_req), .start(s_valid), .tick(tick),
    .ready(s_ready), .accept(accept), .run(run), .shift(shift),
    .sclk(sclk), .cs_n(cs_n), .dac_load(dac_load), .dac_clear(dac_clear)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    dac_lane_shift #(.WORD_W(WORD_W)) i_lane (
      .clk(clk), .rst(rst), .clear(clr_req), .load(accept), .shift(shift),
      .word(s_data[l*WORD_W +: WORD_W]), .sdo(sdo[l])
    );
  end
endmodule

// File: rtl/lane_dac_updater_chk.sv
module lane_dac_updater_chk #(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 16,
  parameter int DIV_W     = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        s_valid,
  input logic                        s_ready,
  input logic [NUM_LANES*WORD_W-1:0] s_data,
  input logic [DIV_W-1:0]            div_half,
  input logic                        clr_req,
  input logic                        sclk,
  input logic                        cs_n,
  input logic [NUM_LANES-1:0]        sdo,
  input logic                        dac_load,
  input logic                        dac_clear
);
  localparam int RC_W = $clog2(WORD_W + 1) + 1;
  logic [RC_W-1:0] rise_cnt;
  logic            sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n)               rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (cs_n && !dac_load));
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (!s_ready && !cs_n));
  p_sdo_stable_r3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo));
  p_rise_bound_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (rise_cnt < RC_W'(WORD_W)));
  p_rise_total_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_n) && !$past(clr_req)) |-> (rise_cnt == RC_W'(WORD_W)));
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  p_cs_lead_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !$past(cs_n));
  p_load_after_cs_r6: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> (cs_n && $past(cs_n)));
  p_load_single_r6: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load);
  p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (cs_n && !sclk && !dac_load && dac_clear && (sdo == '0)));
  p_clear_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> !s_ready);
endmodule

bind lane_dac_updater lane_dac_updater_chk #(
  .NUM_LANES(NUM_LANES), .WORD_W(WORD_W), .DIV_W(DIV_W)
) i_chk (.*);

// File: tb/test_lane_dac_updater.sv
`timescale 1ns/1ps
module test_lane_dac_updater;
  localparam int NL = 4;
  localparam int WW = 16;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            s_valid = 1'b0;
  logic            s_ready;
  logic [NL*WW-1:0] s_data = '0;
  logic [DW-1:0]   div_half = 8'd1;
  logic            clr_req = 1'b0;
  logic            sclk, cs_n, dac_load, dac_clear;
  logic [NL-1:0]   sdo;

  int n_checks = 0;
  int n_fail   = 0;
  int n_loads  = 0;
  int rises    = 0;
  realtime t_prev = 0, per_t = 0;
  logic [WW-1:0] cap [NL];

  always #2.5 clk = ~clk;

  lane_dac_updater #(.NUM_LANES(NL), .WORD_W(WW), .DIV_W(DW)) i_lane_dac_updater (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .div_half(div_half), .clr_req(clr_req), .sclk(sclk), .cs_n(cs_n), .sdo(sdo),
    .dac_load(dac_load), .dac_clear(dac_clear)
  );

  // capture what a DAC would sample at each rising serial clock edge
  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      rises = 0;
      for (int l = 0; l < NL; l++) cap[l] = '0;
    end else if (!cs_n) begin
      for (int l = 0; l < NL; l++) cap[l] = {cap[l][WW-2:0], sdo[l]};
      if (rises > 0) per_t = $realtime - t_prev;
      t_prev = $realtime;
      rises++;
    end
  end

  always @(posedge clk) if (dac_load) n_loads++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1 reset ready", 64'(s_ready), 64'd1);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R4 reset idle lines", {62'd0, cs_n, sclk}, 64'd2);
    chk(dac_load == 1'b0 && dac_clear == 1'b0, "R6 reset strobes",
        {62'd0, dac_load, dac_clear}, 64'd0);
    chk(sdo == '0, "R2 reset lanes", 64'(sdo), 64'd0);
  endtask

  task automatic t_frame(input logic [NL*WW-1:0] words, input logic [DW-1:0] h);
    int  waitc = 0;
    logic p1, p2;
    int  exp_per;
    @(negedge clk);
    div_half = h;
    while (!s_ready) @(negedge clk);
    s_data  = words;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    s_data  = ~words;  // R9: must not reach the lanes
    chk(!s_ready, "R1 busy after accept", 64'(s_ready), 64'd0);
    chk(!cs_n && !sclk, "R5 cs low before first clock", {62'd0, cs_n, sclk}, 64'd0);
    p1 = cs_n; p2 = cs_n;
    while (!dac_load && waitc < 4000) begin
      p2 = p1; p1 = cs_n;
      @(negedge clk);
      waitc++;
    end
    chk(dac_load, "R6 load seen", 64'(dac_load), 64'd1);
    chk(p1 && !p2, "R6 load one clock after cs rise", {62'd0, p2, p1}, 64'd1);
    chk(cs_n && !s_ready, "R1 ready low during load", {62'd0, cs_n, s_ready}, 64'd2);
    chk(rises == WW, "R4 rising edges per frame", 64'(rises), 64'(WW));
    for (int l = 0; l < NL; l++)
      chk(cap[l] == words[l*WW +: WW], "R2 R9 lane word", 64'(cap[l]),
          64'(words[l*WW +: WW]));
    exp_per = 2 * ((h == 0) ? 1 : int'(h)) * 5;
    chk(int'(per_t) == exp_per, "R7 sclk period ns", 64'(int'(per_t)), 64'(exp_per));
    @(negedge clk);
    chk(!dac_load && s_ready, "R1 R6 idle after load", {62'd0, dac_load, s_ready}, 64'd1);
  endtask

  task automatic t_clear();
    int loads0;
    @(negedge clk);
    div_half = 8'd2;
    while (!s_ready) @(negedge clk);
    s_data  = 64'h1111_2222_3333_4444;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    repeat (20) @(negedge clk);
    loads0  = n_loads;
    clr_req = 1'b1;
    #0.1;
    chk(!s_ready, "R8 ready low during clear", 64'(s_ready), 64'd0);
    @(negedge clk);
    clr_req = 1'b0;
    chk(cs_n && !sclk, "R8 lines idle after clear", {62'd0, cs_n, sclk}, 64'd2);
    chk(sdo == '0, "R8 lanes zero after clear", 64'(sdo), 64'd0);
    chk(dac_clear, "R8 clear pulse", 64'(dac_clear), 64'd1);
    repeat (200) @(negedge clk);
    chk(n_loads == loads0, "R8 no load after abort", 64'(n_loads), 64'(loads0));
    chk(s_ready && !dac_clear, "R8 back to idle", {62'd0, s_ready, dac_clear}, 64'd2);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(64'hFFFF_0000_FFFF_0000, 8'd1);
    t_frame(64'h8000_0001_A5A5_3C96, 8'd0);
    t_frame(64'h0102_4080_7FFE_5AC3, 8'd3);
    t_clear();
    t_frame(64'hDEAD_BEEF_0F0F_C001, 8'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule